// File: doc/BRIEF.md
# Partitioned Saturating Lane Adder

This block adds or subtracts two 64-bit operands that are cut into independent lanes. A two-bit lane-size select picks one of four partitions: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. One operation is applied to every lane in the same step. No carry or borrow crosses from one lane into the next.

Each lane is treated as either unsigned or two's-complement signed. Each lane either wraps modulo its width or clamps at the nearest representable limit. Clamping is the form used for pixel and sample arithmetic, where a wrap from the top to the bottom of the range causes a visible or audible fault.

The block takes one operation on a cycle with the input strobe high. It returns the lane results, an 8-bit per-byte clamp indicator and a valid strobe on the next cycle. The registered outputs hold their values while no new operation arrives.

Top module: `lane_sat_adder`

## Requirements
- R1: After reset, `out_vld` is 0, `res_o` is all zeros and `sat_flag_o` is all zeros.
- R2: `out_vld` is 1 exactly in the cycle after a cycle with `in_vld` high, and 0 otherwise. `res_o` and `sat_flag_o` keep their values after a cycle with `in_vld` low.
- R3: `lane_mode` selects the lane width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. Lane k of width w occupies bits [k*w+w-1 : k*w]. No carry or borrow passes between lanes.
- R4: With `sat_en` = 0, each lane result is (a op b) mod 2^w, the carry out of the lane is discarded, and every bit of `sat_flag_o` is 0.
- R5: With `sat_en` = 1, `signed_en` = 0 and `sub` = 0, a lane whose true sum exceeds 2^w-1 yields all ones.
- R6: With `sat_en` = 1, `signed_en` = 0 and `sub` = 1, a lane whose true difference is below zero yields zero.
- R7: With `sat_en` = 1 and `signed_en` = 1, a lane whose true result exceeds 2^(w-1)-1 yields that most positive value. A lane whose true result is below -2^(w-1) yields that most negative value.
- R8: `sub` = 1 computes a - b in each lane, and `sub` = 0 computes a + b.
- R9: Bit j of `sat_flag_o` is 1 exactly when byte j (bits 8j+7..8j) lies in a lane that was clamped. All bytes of one lane carry the same flag.
- R10: In 8-bit unsigned clamping add mode, feeding each result back as `a` while adding 1 in every byte counts up to 8'hFF and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operation strobe |
| lane_mode | input | 2 | Lane width select (00=8, 01=16, 10=32, 11=64 bits) |
| sub | input | 1 | 1 = subtract b from a, 0 = add |
| signed_en | input | 1 | 1 = lanes are two's-complement signed |
| sat_en | input | 1 | 1 = clamp at the lane limits, 0 = wrap |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| res_o | output | 64 | Lane results |
| sat_flag_o | output | 8 | Per-byte clamp indicator |

## Verification
Every result appears one register after the operation. The bench drives an operation on a falling edge and drops the strobe on the next falling edge. It then compares `out_vld`, `res_o` and `sat_flag_o` at that same falling edge, which lies half a cycle after the capturing rising edge. One more falling edge later, with different operands on the inputs and the strobe low, it confirms that the strobe has fallen and the outputs are unchanged. This checks the hold behaviour one full cycle after the operation. The feedback counter uses the same one-cycle spacing, so each step reads the result that the previous operation produced.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // lane size select encoding
    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_mode_e;

    // how a slice replaces its raw sum
    typedef enum logic [2:0] {
        CLAMP_NONE = 3'd0,
        CLAMP_ONES = 3'd1,
        CLAMP_ZERO = 3'd2,
        CLAMP_SPOS = 3'd3,
        CLAMP_SNEG = 3'd4
    } clamp_e;

endpackage

// File: rtl/lsa_slice_add.sv
module lsa_slice_add #(
    parameter int SW = 8
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b_eff,
    input  logic          cin,
    output logic [SW-1:0] sum,
    output logic          cout,
    output logic          ovf_s
);

    logic [SW:0] full_sum;

    always_comb begin
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{SW{1'b0}}, cin};
        sum      = full_sum[SW-1:0];
        cout     = full_sum[SW];
        // signed overflow: operands agree in sign, result does not
        ovf_s    = (a[SW-1] == b_eff[SW-1]) && (full_sum[SW-1] != a[SW-1]);
    end

endmodule

// File: rtl/lsa_lane_map.sv
module lsa_lane_map #(
    parameter int NS = 8,
    parameter int IW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [1:0]               mode,
    output logic [NS-1:0]            first,
    output logic [NS-1:0]            last,
    output logic [NS-1:0][IW-1:0]    top_idx
);

    localparam int MAXM = (NS > 1) ? $clog2(NS) : 0;

    logic [IW-1:0] span_m1;

    always_comb begin
        int m;
        m = int'(mode);
        if (m > MAXM) m = MAXM;
        span_m1 = IW'((1 << m) - 1);
    end

    for (genvar i = 0; i < NS; i++) begin : g_map
        localparam logic [IW-1:0] IDX = IW'(i);
        assign first[i]   = ((IDX & span_m1) == '0);
        assign last[i]    = ((IDX & span_m1) == span_m1);
        assign top_idx[i] = IDX | span_m1;
    end

endmodule

// File: rtl/lsa_clamp.sv
module lsa_clamp
    import lsa_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic [SW-1:0] sum,
    input  logic          is_top,
    input  clamp_e        kind,
    output logic [SW-1:0] res
);

    always_comb begin
        unique case (kind)
            CLAMP_ONES: res = '1;
            CLAMP_ZERO: res = '0;
            CLAMP_SPOS: res = is_top ? {1'b0, {(SW-1){1'b1}}} : '1;
            CLAMP_SNEG: res = is_top ? {1'b1, {(SW-1){1'b0}}} : '0;
            default:    res = sum;
        endcase
    end

endmodule

// File: rtl/lane_sat_adder.sv
module lane_sat_adder
    import lsa_pkg::*;
#(
    parameter int SW = 8,
    parameter int NS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [1:0]       lane_mode,
    input  logic             sub,
    input  logic             signed_en,
    input  logic             sat_en,
    input  logic [SW*NS-1:0] a_i,
    input  logic [SW*NS-1:0] b_i,
    output logic             out_vld,
    output logic [SW*NS-1:0] res_o,
    output logic [NS-1:0]    sat_flag_o
);

    localparam int DW = SW * NS;
    localparam int IW = (NS > 1) ? $clog2(NS) : 1;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
        logic [NS-1:0] flg;
    } lsa_state_t;

    lsa_state_t st_d, st_q;

    logic [NS-1:0]          first_w, last_w, cin_w, cout_w, ovf_w, flg_w;
    logic [NS-1:0][IW-1:0]  top_idx_w;
    logic [NS-1:0][SW-1:0]  beff_w, sum_w, slc_w;
    clamp_e                 dec_w [NS];
    clamp_e                 sel_w [NS];

    lsa_lane_map #(.NS(NS), .IW(IW)) u_map (
        .mode    (lane_mode),
        .first   (first_w),
        .last    (last_w),
        .top_idx (top_idx_w)
    );

    for (genvar i = 0; i < NS; i++) begin : g_slice
        assign beff_w[i] = sub ? ~b_i[i*SW +: SW] : b_i[i*SW +: SW];

        if (i == 0) begin : g_c0
            assign cin_w[i] = sub;
        end else begin : g_cn
            assign cin_w[i] = first_w[i] ? sub : cout_w[i-1];
        end

        lsa_slice_add #(.SW(SW)) u_add (
            .a     (a_i[i*SW +: SW]),
            .b_eff (beff_w[i]),
            .cin   (cin_w[i]),
            .sum   (sum_w[i]),
            .cout  (cout_w[i]),
            .ovf_s (ovf_w[i])
        );

        // clamp decision, meaningful only at the top slice of a lane
        always_comb begin
            dec_w[i] = CLAMP_NONE;
            if (sat_en && last_w[i]) begin
                if (signed_en) begin
                    if (ovf_w[i])
                        dec_w[i] = a_i[i*SW+SW-1] ? CLAMP_SNEG : CLAMP_SPOS;
                end else if (sub) begin
                    if (!cout_w[i]) dec_w[i] = CLAMP_ZERO;
                end else begin
                    if (cout_w[i]) dec_w[i] = CLAMP_ONES;
                end
            end
        end

        // every slice follows the decision taken at its lane's top
        assign sel_w[i] = dec_w[top_idx_w[i]];
        assign flg_w[i] = (sel_w[i] != CLAMP_NONE);

        lsa_clamp #(.SW(SW)) u_clamp (
            .sum    (sum_w[i]),
            .is_top (last_w[i]),
            .kind   (sel_w[i]),
            .res    (slc_w[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.res = slc_w;
            st_d.flg = flg_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld    = st_q.vld;
    assign res_o      = st_q.res;
    assign sat_flag_o = st_q.flg;

    // independent full-width reference terms for the 64-bit lane checks
    logic [DW:0] chk_usum;
    logic        chk_borrow;
    assign chk_usum   = {1'b0, a_i} + {1'b0, b_i};
    assign chk_borrow = (a_i < b_i);

    AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);                                               // R2
    AST_VLD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);                                             // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(res_o) && $stable(sat_flag_o)));              // R2
    AST_WRAP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !sat_en) |=> (sat_flag_o == '0));                       // R4
    AST_LANE0_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !sat_en && !sub && lane_mode == LANE_8)
        |=> (res_o[SW-1:0] == $past(a_i[SW-1:0] + b_i[SW-1:0])));         // R3
    AST_UADD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && sat_en && !signed_en && !sub && lane_mode == LANE_64
         && NS == 8 && chk_usum[DW])
        |=> (res_o == '1 && sat_flag_o == '1));                            // R5
    AST_USUB_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && sat_en && !signed_en && sub && lane_mode == LANE_64
         && NS == 8 && chk_borrow)
        |=> (res_o == '0 && sat_flag_o == '1));                            // R6

endmodule

// File: tb/lane_sat_adder_bench.sv
`timescale 1ns/1ps
module lane_sat_adder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  lane_mode = 2'b00;
    logic        sub = 1'b0, signed_en = 1'b0, sat_en = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic        out_vld;
    logic [63:0] res_o;
    logic [7:0]  sat_flag_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    lane_sat_adder u_lane_sat_adder (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .lane_mode(lane_mode),
        .sub(sub), .signed_en(signed_en), .sat_en(sat_en),
        .a_i(a_i), .b_i(b_i), .out_vld(out_vld), .res_o(res_o),
        .sat_flag_o(sat_flag_o)
    );

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    // edge-heavy operand: each byte from a small set of limit values
    function automatic logic [63:0] edge_val(input logic [63:0] r);
        logic [63:0] v;
        logic [7:0]  pick [8];
        pick = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h40};
        v = '0;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = pick[r[k*3 +: 3]];
        return v;
    endfunction

    task automatic model(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] md, input logic sb, input logic sg,
                         input logic st, output logic [63:0] r,
                         output logic [7:0] f);
        int w, nl;
        w  = 8 << md;
        nl = 64 / w;
        r  = '0;
        f  = '0;
        for (int L = 0; L < nl; L++) begin
            logic [63:0] mask, lv;
            logic signed [65:0] ea, eb, rr, mx, mn;
            logic clamp;
            mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            ea = {2'b00, (a >> (L*w)) & mask};
            eb = {2'b00, (b >> (L*w)) & mask};
            if (sg && ea[w-1]) ea = ea - (66'sd1 <<< w);
            if (sg && eb[w-1]) eb = eb - (66'sd1 <<< w);
            rr = sb ? (ea - eb) : (ea + eb);
            mx = sg ? ((66'sd1 <<< (w-1)) - 66'sd1) : ((66'sd1 <<< w) - 66'sd1);
            mn = sg ? -(66'sd1 <<< (w-1)) : 66'sd0;
            clamp = 1'b0;
            if (st && rr > mx) begin rr = mx; clamp = 1'b1; end
            if (st && rr < mn) begin rr = mn; clamp = 1'b1; end
            lv = rr[63:0] & mask;
            r  = r | (lv << (L*w));
            if (clamp)
                for (int k = 0; k < w/8; k++) f[L*(w/8) + k] = 1'b1;
        end
    endtask

    task automatic chk64(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // one operation: strobe on a falling edge, compare half a cycle after capture
    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] md, input logic sb,
                          input logic sg, input logic st, input string req);
        logic [63:0] er;
        logic [7:0]  ef;
        model(a, b, md, sb, sg, st, er, ef);
        @(negedge clk);
        a_i = a; b_i = b; lane_mode = md; sub = sb; signed_en = sg; sat_en = st;
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        chk64({req, " R2 vld"}, {63'd0, out_vld}, 64'd1);
        chk64({req, " res"}, res_o, er);
        chk64({req, " R9 flag"}, {56'd0, sat_flag_o}, {56'd0, ef});
    endtask

    // R2: no strobe, new operands, outputs must hold
    task automatic hold_check();
        logic [63:0] pr;
        logic [7:0]  pf;
        pr = res_o;
        pf = sat_flag_o;
        a_i = ~a_i; b_i = next_rand();
        @(negedge clk);
        chk64("R2 vld low", {63'd0, out_vld}, 64'd0);
        chk64("R2 res hold", res_o, pr);
        chk64("R2 flag hold", {56'd0, sat_flag_o}, {56'd0, pf});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk64("R1 vld", {63'd0, out_vld}, 64'd0);
        chk64("R1 res", res_o, 64'd0);
        chk64("R1 flag", {56'd0, sat_flag_o}, 64'd0);
        rst_n = 1'b1;

        // directed corners
        run_op('1, 64'd1, 2'b11, 1'b0, 1'b0, 1'b1, "R5 quad max");
        run_op(64'd3, 64'd5, 2'b11, 1'b1, 1'b0, 1'b1, "R6 quad floor");
        run_op(64'h7FFF_7FFF_8000_8000, 64'h0001_0001_FFFF_FFFF, 2'b01,
               1'b0, 1'b1, 1'b1, "R7 word limits");
        run_op(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b00,
               1'b0, 1'b0, 1'b0, "R3 R4 byte wrap no cross");
        run_op(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'b10,
               1'b1, 1'b0, 1'b0, "R8 R4 dword borrow wrap");
        hold_check();

        // sweep all configurations, random and limit-value operands
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int v = 0; v < 160; v++) begin
                logic [63:0] x, y;
                x = next_rand();
                y = next_rand();
                if (v[0]) begin x = edge_val(x); y = edge_val(y); end
                run_op(x, y, cfg[1:0], cfg[2], cfg[3], 1'b1, "R3 R5 R6 R7 R8 sat sweep");
                run_op(x, y, cfg[1:0], cfg[2], cfg[3], 1'b0, "R4 R8 wrap sweep");
                if (v % 32 == 0) hold_check();
            end
        end

        // R10 feedback counter in unsigned clamping byte mode
        begin
            logic [63:0] acc;
            acc = {8{8'hFB}};
            for (int s = 0; s < 8; s++) begin
                run_op(acc, {8{8'h01}}, 2'b00, 1'b0, 1'b0, 1'b1, "R10 step");
                chk64("R10 count", res_o,
                      {8{(s >= 4) ? 8'hFF : 8'(8'hFC + s)}});
                acc = res_o;
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule